// File: doc/BRIEF.md
# Cascade Repeater ID Assigner

This block gives every chip in a cascade of up to eight repeaters its own 5-bit identifier. Each chip listens on a serial chain input for the identifier of the chip before it. It takes that value plus one as its own low three bits and repeats its own low bits on a serial chain output, at a fixed interval, for the next chip. The two high bits come from a local strap. The strap must hold the same value on every chip of the cascade. Address decoding elsewhere can compare a management device address with the result.

The link carries a short asynchronous frame. The line rests high. A frame is a low start bit, then the three low ID bits with the least significant bit first, then a high stop bit. Each bit lasts `BIT_CYC` clock cycles. The first chip of a chain sees no frames, so after a silence of two transmit periods it falls back to low ID 0. A frame whose stop bit is low is thrown away.

Top module: `rid_assigner`

## Requirements
- R1: A received frame with a high stop bit sets the low ID bits `rep_id[2:0]` to the received 3-bit value plus one. Frame format: line idle high, start bit 0, ID bits 0, 1, 2, stop bit 1, each bit `BIT_CYC` cycles.
- R2: The increment is modulo 8, so a received value of 7 gives low ID 0.
- R3: A received frame whose stop bit is 0 is discarded and leaves `rep_id[2:0]` unchanged. A low line after such a frame does not start a new frame until the line has been high again.
- R4: Every `PERIOD_CYC` cycles, the first time `PERIOD_CYC` cycles after reset, `chain_out` sends one frame in the R1 format carrying the current `rep_id[2:0]`.
- R5: `rep_id[4:3]` always equals `strap_hi`.
- R6: When no valid frame has arrived for `2*PERIOD_CYC` cycles, `rep_id[2:0]` becomes 0. Before that time it keeps its value.
- R7: During and right after reset, `rep_id[2:0]` is 0 and `chain_out` is high.
- R8: `addr_match` is 1 exactly when `dev_addr` equals the full 5-bit `rep_id`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_in | input | 1 | Serial ID from the previous chip, idle high |
| strap_hi | input | 2 | Local strap for ID bits 4:3 |
| dev_addr | input | 5 | Management device address to compare |
| chain_out | output | 1 | Serial ID to the next chip, idle high |
| rep_id | output | 5 | Resulting repeater ID |
| addr_match | output | 1 | High when dev_addr equals rep_id |

## Verification
Each received frame passes a two-flop synchronizer and is sampled in the middle of its stop bit, so the new ID appears a few cycles after the stop bit's midpoint. The bench therefore checks two bit times after the stop bit ends. The strap bits and the address compare are combinational and are checked one time step after the inputs change. Transmitted frames are decoded at the middle of each bit, measured from the falling start edge. Their spacing is measured in cycles and must be exactly one period. The fallback to ID 0 is checked well before and well after the `2*PERIOD_CYC` point, which keeps every sample clear of the few cycles of pipeline delay.

// File: rtl/rid_pkg.sv
package rid_pkg;

    localparam int LOW_W = 3;
    localparam int HI_W  = 2;
    localparam int ID_W  = LOW_W + HI_W;
    localparam int FRAME_BITS = LOW_W + 2;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_DRAIN
    } rx_state_e;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [LOW_W-1:0] lo;
    } rep_id_t;

    typedef struct packed {
        logic             ok;
        logic             bad;
        logic [LOW_W-1:0] value;
    } rx_result_t;

    function automatic logic [LOW_W-1:0] succ_id(input logic [LOW_W-1:0] v);
        return v + LOW_W'(1);
    endfunction

    // payload after the start bit, LSB first: ID bits then the stop bit
    function automatic logic [LOW_W:0] tx_payload(input logic [LOW_W-1:0] v);
        return {1'b1, v};
    endfunction

endpackage

// File: rtl/chain_rx.sv
module chain_rx
    import rid_pkg::*;
#(
    parameter int BIT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    output rx_result_t result
);
    localparam int CNT_W = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam int HALF  = BIT_CYC / 2;
    localparam int IDX_W = $clog2(LOW_W + 1);

    logic              sync_a, sync_b;
    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [LOW_W-1:0]  shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
        end else begin
            sync_a <= line_in;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            result <= '0;
        end else begin
            result.ok  <= 1'b0;
            result.bad <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!sync_b) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == CNT_W'(HALF - 1)) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= sync_b ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == CNT_W'(BIT_CYC - 1)) begin
                        cnt   <= '0;
                        shreg <= {sync_b, shreg[LOW_W-1:1]};
                        if (idx == IDX_W'(LOW_W - 1)) state <= RX_STOP;
                        else idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == CNT_W'(BIT_CYC - 1)) begin
                        cnt          <= '0;
                        result.value <= shreg;
                        if (sync_b) begin
                            result.ok <= 1'b1;
                            state     <= RX_IDLE;
                        end else begin
                            result.bad <= 1'b1;
                            state      <= RX_DRAIN;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DRAIN: begin
                    if (sync_b) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/chain_tx.sv
module chain_tx
    import rid_pkg::*;
#(
    parameter int BIT_CYC    = 16,
    parameter int PERIOD_CYC = 50000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LOW_W-1:0] low_id,
    output logic             line_out
);
    localparam int PW    = $clog2(PERIOD_CYC);
    localparam int CNT_W = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
    localparam int IDX_W = $clog2(FRAME_BITS);

    logic [PW-1:0]    pcnt;
    logic             busy;
    logic [LOW_W:0]   shreg;
    logic [CNT_W-1:0] ccnt;
    logic [IDX_W-1:0] bidx;
    logic             launch;

    assign launch = (pcnt == PW'(PERIOD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else begin
            pcnt <= launch ? '0 : pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            shreg    <= '1;
            ccnt     <= '0;
            bidx     <= '0;
            line_out <= 1'b1;
        end else if (launch) begin
            busy     <= 1'b1;
            shreg    <= tx_payload(low_id);
            ccnt     <= '0;
            bidx     <= '0;
            line_out <= 1'b0;
        end else if (busy) begin
            if (ccnt == CNT_W'(BIT_CYC - 1)) begin
                ccnt <= '0;
                if (bidx == IDX_W'(FRAME_BITS - 1)) begin
                    busy     <= 1'b0;
                    line_out <= 1'b1;
                end else begin
                    line_out <= shreg[0];
                    shreg    <= {1'b1, shreg[LOW_W:1]};
                    bidx     <= bidx + 1'b1;
                end
            end else begin
                ccnt <= ccnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/id_keeper.sv
module id_keeper
    import rid_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  rx_result_t       rx,
    output logic [LOW_W-1:0] low_id
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_id <= '0;
            quiet  <= '0;
        end else if (rx.ok) begin
            low_id <= succ_id(rx.value);
            quiet  <= '0;
        end else if (quiet != TW'(TIMEOUT_CYC)) begin
            quiet <= quiet + 1'b1;
            if (quiet == TW'(TIMEOUT_CYC - 1)) low_id <= '0;
        end
    end

endmodule

// File: rtl/rid_assigner.sv
module rid_assigner
    import rid_pkg::*;
#(
    parameter int BIT_CYC    = 16,
    parameter int PERIOD_CYC = 50000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chain_in,
    input  logic [HI_W-1:0] strap_hi,
    input  logic [ID_W-1:0] dev_addr,
    output logic            chain_out,
    output logic [ID_W-1:0] rep_id,
    output logic            addr_match
);
    localparam int TIMEOUT_CYC = 2 * PERIOD_CYC;

    rx_result_t       rx_res;
    logic [LOW_W-1:0] low_id;
    rep_id_t          id_s;
    logic             rx_ok, rx_bad;
    logic [LOW_W-1:0] rx_data;

    chain_rx #(.BIT_CYC(BIT_CYC)) rx_i (
        .clk(clk), .rst(rst), .line_in(chain_in), .result(rx_res)
    );

    id_keeper #(.TIMEOUT_CYC(TIMEOUT_CYC)) keep_i (
        .clk(clk), .rst(rst), .rx(rx_res), .low_id(low_id)
    );

    chain_tx #(.BIT_CYC(BIT_CYC), .PERIOD_CYC(PERIOD_CYC)) tx_i (
        .clk(clk), .rst(rst), .low_id(low_id), .line_out(chain_out)
    );

    assign rx_ok   = rx_res.ok;
    assign rx_bad  = rx_res.bad;
    assign rx_data = rx_res.value;

    always_comb begin
        id_s.hi = strap_hi;
        id_s.lo = low_id;
    end

    assign rep_id     = id_s;
    assign addr_match = (dev_addr == rep_id);

endmodule

// File: rtl/rid_assigner_chk.sv
module rid_assigner_chk (
    input logic       clk,
    input logic       rst,
    input logic       chain_out,
    input logic [4:0] rep_id,
    input logic       rx_ok,
    input logic       rx_bad,
    input logic [2:0] rx_data
);
    AST_INC_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        rx_ok |=> rep_id[2:0] == 3'($past(rx_data) + 3'd1)); // R1

    AST_FRAME_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_ok, rx_bad})); // R3

    AST_BAD_FRAME_KEEPS: assert property (@(posedge clk) disable iff (rst)
        rx_bad |=> ($stable(rep_id[2:0]) || rep_id[2:0] == 3'd0)); // R3

    AST_LOW_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (rst)
        !rx_ok |=> ($stable(rep_id[2:0]) || rep_id[2:0] == 3'd0)); // R6

    AST_RESET_LINE_HIGH: assert property (@(posedge clk)
        $past(rst) |-> (chain_out && rep_id[2:0] == 3'd0)); // R7
endmodule

bind rid_assigner rid_assigner_chk chk_i (
    .clk(clk), .rst(rst), .chain_out(chain_out), .rep_id(rep_id),
    .rx_ok(rx_ok), .rx_bad(rx_bad), .rx_data(rx_data)
);

// File: tb/rid_assigner_tb_top.sv
module rid_assigner_tb_top;
    localparam int BIT    = 4;
    localparam int PERIOD = 64;
    localparam int NVEC   = 5;
    // octal: high digit = received value, low digit = expected low ID
    localparam logic [5:0] VEC [NVEC] = '{6'o01, 6'o34, 6'o67, 6'o70, 6'o56};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chain_in = 1'b1;
    logic [1:0] strap_hi = 2'b01;
    logic [4:0] dev_addr = '0;
    logic       chain_out, addr_match;
    logic [4:0] rep_id;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rid_assigner #(.BIT_CYC(BIT), .PERIOD_CYC(PERIOD)) dut_i (
        .clk(clk), .rst(rst), .chain_in(chain_in), .strap_hi(strap_hi),
        .dev_addr(dev_addr), .chain_out(chain_out), .rep_id(rep_id),
        .addr_match(addr_match)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [2:0] v, input logic stop);
        logic [4:0] bits;
        bits = {stop, v, 1'b0};
        for (int k = 0; k < 5; k++) begin
            chain_in = bits[k];
            repeat (BIT) @(negedge clk);
        end
        chain_in = 1'b1;
    endtask

    task automatic capture_tx(output logic [2:0] v, output int t);
        int run;
        run = 0;
        while (run < 5 * BIT) begin
            @(negedge clk);
            run = chain_out ? run + 1 : 0;
        end
        while (chain_out) @(negedge clk);
        t = cyc;
        repeat (BIT / 2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            repeat (BIT) @(negedge clk);
            v[k] = chain_out;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] got;
        int t0, t1;
        repeat (3) @(negedge clk);
        // R7 during reset
        chk(rep_id == 5'b01000, "R7 reset id", rep_id, 5'b01000);
        chk(chain_out == 1'b1, "R7 reset line", chain_out, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(chain_out == 1'b1, "R7 after reset line", chain_out, 1);

        // R4 period and content (low ID 0 after reset)
        capture_tx(got, t0);
        chk(got == 3'd0, "R4 tx id after reset", got, 0);
        capture_tx(got, t1);
        chk(t1 - t0 == PERIOD, "R4 period", t1 - t0, PERIOD);

        // R1, R2, R4, R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VEC[i][5:3], 1'b1);
            repeat (2 * BIT) @(negedge clk);
            chk(rep_id[2:0] == VEC[i][2:0], (VEC[i][5:3] == 3'd7) ? "R2 wrap" : "R1 increment",
                rep_id[2:0], VEC[i][2:0]);
            dev_addr = {strap_hi, VEC[i][2:0]};
            #1;
            chk(addr_match == 1'b1, "R8 match", addr_match, 1);
            capture_tx(got, t0);
            chk(got == VEC[i][2:0], "R4 tx carries id", got, VEC[i][2:0]);
        end

        // R3 bad stop bit: current low ID is 6
        send_frame(3'd2, 1'b0);
        repeat (3 * BIT) @(negedge clk);
        chk(rep_id[2:0] == 3'd6, "R3 bad stop kept", rep_id[2:0], 6);
        send_frame(3'd1, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        chk(rep_id[2:0] == 3'd2, "R3 next good frame", rep_id[2:0], 2);

        // R5 strap and R8 mismatch
        strap_hi = 2'b10;
        dev_addr = 5'b01010;
        #1;
        chk(rep_id[4:3] == 2'b10, "R5 strap", rep_id[4:3], 2);
        chk(addr_match == 1'b0, "R8 mismatch", addr_match, 0);
        dev_addr = 5'b10010;
        #1;
        chk(addr_match == 1'b1, "R8 match new strap", addr_match, 1);

        // R6 fallback after silence
        @(negedge clk);
        send_frame(3'd2, 1'b1);
        repeat (100) @(negedge clk);
        chk(rep_id[2:0] == 3'd3, "R6 held before timeout", rep_id[2:0], 3);
        repeat (40) @(negedge clk);
        chk(rep_id[2:0] == 3'd0, "R6 fallback to 0", rep_id[2:0], 0);

        // R7 reset again mid-operation
        send_frame(3'd4, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rep_id[2:0] == 3'd0, "R7 reset clears id", rep_id[2:0], 0);
        chk(chain_out == 1'b1, "R7 reset idles line", chain_out, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule